// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block watches over system software. A timeout counter runs on its own watchdog clock, which is separate from the bus clock and nominally 1 MHz. Software has to restart the counter before the selected timeout runs out. If it does not, the block raises a one-cycle reset request towards the chip's reset logic. The counter then begins again from zero, so the request repeats for as long as nobody restarts it.

Software controls the block through one 8-bit register, which it reads and writes over a plain synchronous port in the bus clock domain. The register has an enable bit, a change-enable bit and a 3-bit timeout select. Turning the watchdog on is always allowed. Turning it off needs two writes. The first write sets change-enable and enable together, which opens a short window. The second write, made inside that window, clears enable. When the static strict-mode input is high, the timeout select can only be changed while that window is open. All pins are plain control pins: there is no stream, so there is no back-pressure to manage.

The enable bit and the timeout select reach the watchdog domain through two-flop synchronizers. The restart strobe and the reset request each cross between the domains as a toggle.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `rdata` reads 0x00 and `rst_req` stays low.
- R2: `rdata` reads {3'b000, change-enable at bit 4, enable at bit 3, timeout select at bits 2..0}. Bits 7..5 ignore writes and always read zero.
- R3: A write with bit 3 = 1 always sets enable. While enable is 0, the counter does not run and no reset request is raised.
- R4: With select code c, the timeout is 2^(BASE_LOG2+c) watchdog clock cycles (BASE_LOG2=14 gives 16K to 2048K). Each timeout gives a `rst_req` pulse one bus clock wide. The count then restarts, so unserviced timeouts repeat with that same period.
- R5: A one-cycle `kick` clears the count. A kick strobe may be repeated no more often than once every three watchdog clock cycles.
- R6: A write with bit 4 = 1 and bit 3 = 1 sets change-enable. Change-enable reads as 1 for exactly WIN (4) bus clock cycles, and the hardware then clears it.
- R7: A write with bit 3 = 0 clears enable only if change-enable was already 1 before that write. This includes a write on the last cycle of the window.
- R8: A write with bit 3 = 0 made after the window has closed leaves enable at 1.
- R9: With `strict_mode` = 1, a write updates bits 2..0 only if change-enable was already 1 before the write. With `strict_mode` = 0, every write updates bits 2..0.
- R10: Disabling the watchdog clears the count. After it is enabled again, a full timeout passes before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, both domains |
| wdt_clk | input | 1 | Free-running watchdog clock |
| strict_mode | input | 1 | Static safety level; 1 guards the timeout select |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| kick | input | 1 | Restart strobe, one bus cycle |
| rst_req | output | 1 | Reset request pulse, one bus cycle |

## Verification
The bench builds the block with BASE_LOG2 = 3 and the default window of four cycles. With those values every select code gives a timeout of 8 to 1024 watchdog cycles. That brings all eight timeouts, their periodic repeats, and repeated kicks well short of a timeout within a short run. The watchdog clock runs at one fifth of the bus clock rate. This lets the bench measure each timeout in watchdog cycles, with a small allowance for synchronizer latency. The two window boundaries, the last cycle that accepts a disable and the first that rejects one, are hit exactly.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int REG_W  = 8;
  localparam int PS_W   = 3;
  localparam int BIT_CE = 4;
  localparam int BIT_EN = 3;

  typedef struct packed {
    logic            ce;
    logic            en;
    logic [PS_W-1:0] ps;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_guard_sync.sv
module wdt_guard_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdt_guard_xfer.sv
module wdt_guard_xfer (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  logic tog, tog_s, tog_d;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= tog ^ src_pulse;
  end

  wdt_guard_sync #(.W(1)) u_sync (
    .clk(dst_clk), .rst_n(rst_n), .d(tog), .q(tog_s)
  );

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  assign dst_pulse = tog_s ^ tog_d;
endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strict_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output wdt_ctrl_t        ctrl
);
  localparam int WW = $clog2(WIN + 1);

  logic [WW-1:0] left;
  logic          arm;

  assign arm = wr_en & wdata[BIT_CE] & wdata[BIT_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      left <= '0;
    end else begin
      if (wr_en) begin
        if (wdata[BIT_EN])  ctrl.en <= 1'b1;
        else if (ctrl.ce)   ctrl.en <= 1'b0;
        if (!strict_mode || ctrl.ce) ctrl.ps <= wdata[PS_W-1:0];
      end
      if (arm) begin
        ctrl.ce <= 1'b1;
        left    <= WW'(WIN - 1);
      end else if (ctrl.ce) begin
        if (left == '0) ctrl.ce <= 1'b0;
        else            left    <= left - 1'b1;
      end
    end
  end

  logic [7:0] ce_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ce_age <= '0;
    else if (arm)     ce_age <= 8'd1;
    else if (ctrl.ce) ce_age <= ce_age + 8'd1;
    else              ce_age <= '0;
  end

  // R6
  ce_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ctrl.ce);
  // R6
  ce_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ce |-> (ce_age <= 8'(WIN)));
  // R7
  locked_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_EN] && !ctrl.ce && ctrl.en) |=> ctrl.en);
  // R9
  strict_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_mode && !ctrl.ce) |=> $stable(ctrl.ps));
endmodule

// File: rtl/wdt_guard_counter.sv
module wdt_guard_counter #(
  parameter int BASE_LOG2 = 14,
  parameter int PS_W      = 3
) (
  input  logic            wdt_clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            expire
);
  localparam int CNT_W = BASE_LOG2 + (1 << PS_W);

  logic [CNT_W-1:0] cnt, last;

  assign last = (CNT_W'(1) << (BASE_LOG2 + int'(ps))) - CNT_W'(1);

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!en || clr) begin
        cnt <= '0;
      end else if (cnt >= last) begin
        cnt    <= '0;
        expire <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  off_clear_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R5
  kick_clear_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R4
  wrap_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    expire |-> (cnt == '0));
  // R4
  early_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    (en && !clr && cnt < last) |=> !expire);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int WIN       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_clk,
  input  logic       strict_mode,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       kick,
  output logic       rst_req
);
  wdt_ctrl_t       ctrl;
  logic [PS_W:0]   cfg_w;
  logic            clr_w, expire_w;

  wdt_guard_ctrl #(.WIN(WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .wr_en(wr_en), .wdata(wdata), .ctrl(ctrl)
  );

  wdt_guard_sync #(.W(PS_W + 1)) u_cfg_sync (
    .clk(wdt_clk), .rst_n(rst_n), .d({ctrl.en, ctrl.ps}), .q(cfg_w)
  );

  wdt_guard_xfer u_kick_xfer (
    .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
    .src_pulse(kick), .dst_pulse(clr_w)
  );

  wdt_guard_counter #(.BASE_LOG2(BASE_LOG2), .PS_W(PS_W)) u_cnt (
    .wdt_clk(wdt_clk), .rst_n(rst_n), .en(cfg_w[PS_W]),
    .ps(cfg_w[PS_W-1:0]), .clr(clr_w), .expire(expire_w)
  );

  wdt_guard_xfer u_req_xfer (
    .src_clk(wdt_clk), .dst_clk(clk), .rst_n(rst_n),
    .src_pulse(expire_w), .dst_pulse(rst_req)
  );

  assign rdata = {3'b000, ctrl.ce, ctrl.en, ctrl.ps};

  // R4
  req_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R3
  off_quiet_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    !cfg_w[PS_W] |=> !expire_w);
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  localparam int BL = 3;

  logic clk = 1'b0, wdt_clk = 1'b0, rst_n = 1'b0, strict_mode = 1'b0;
  logic wr_en = 1'b0, kick = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rst_req;

  int checks = 0, fails = 0;
  int wcount = 0, npulse = 0, last_w = 0, cyc = 0;
  logic prev_req = 1'b0;
  bit m_ce = 0, m_en = 0;
  logic [2:0] m_ps = 3'd0;
  int m_left = 0;
  bit done = 0;

  wdt_guard #(.BASE_LOG2(BL), .WIN(4)) dut (
    .clk(clk), .rst_n(rst_n), .wdt_clk(wdt_clk), .strict_mode(strict_mode),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .kick(kick), .rst_req(rst_req)
  );

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #10 wdt_clk = ~wdt_clk;
  end
  always @(posedge wdt_clk) wcount++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference model of the register, one step per bus clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ce = 0; m_en = 0; m_ps = 3'd0; m_left = 0;
    end else begin
      bit ce_before;
      ce_before = m_ce;
      if (wr_en) begin
        if (wdata[3]) m_en = 1;
        else if (ce_before) m_en = 0;
        if (!strict_mode || ce_before) m_ps = wdata[2:0];
      end
      if (wr_en && wdata[4] && wdata[3]) begin
        m_ce = 1; m_left = 4;
      end else if (m_ce) begin
        m_left--;
        if (m_left == 0) m_ce = 0;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(rdata == {3'b000, m_ce, m_en, m_ps}, "R2 register model",
            int'(rdata), int'({3'b000, m_ce, m_en, m_ps}));
      if (rst_req) begin
        npulse++;
        last_w = wcount;
        if (prev_req) check(0, "R4 pulse width", 2, 1);
      end
      prev_req = rst_req;
    end
    if (cyc > 150000) begin
      check(0, "watchdog expired", cyc, 150000);
      finish_up();
    end
  end

  // tasks are entered just after a falling edge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick_once();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic idle_w(input int n);
    repeat (n * 5) @(negedge clk);
  endtask

  task automatic measure(input int n, input bit do_kick, input string tag);
    int start, p0, t, el, w1;
    start = wcount;
    if (do_kick) kick_once();
    idle_w(6);
    p0 = npulse; t = 0;
    while (npulse == p0 && t < n * 5 * 2 + 200) begin
      @(negedge clk); t++;
    end
    el = last_w - start;
    check(npulse != p0 && el >= n && el <= n + 6, tag, el, n + 3);
    w1 = last_w; p0 = npulse; t = 0;
    while (npulse == p0 && t < n * 5 * 2 + 200) begin
      @(negedge clk); t++;
    end
    el = last_w - w1;
    check(npulse != p0 && el >= n - 1 && el <= n + 1, {tag, " period"}, el, n);
  endtask

  task automatic reset_dut(input logic strict);
    @(negedge clk);
    rst_n = 1'b0; strict_mode = strict;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int p;
    reset_dut(1'b0);
    // R1 reset state
    check(rdata == 8'h00, "R1 reset value", int'(rdata), 0);
    p = npulse;
    idle_w(60);
    check(npulse == p, "R1 R3 no request while off", npulse - p, 0);

    // R2 reserved bits ignored
    wr(8'hE5);
    check(rdata == 8'h05, "R2 reserved bits", int'(rdata), 5);

    // R3 enable
    wr(8'h08);
    check(rdata[3] == 1'b1, "R3 enable set", int'(rdata[3]), 1);

    // R4 every select code
    for (int c = 0; c < 8; c++) begin
      wr(8'h08 | 8'(c));
      measure(8 << c, 1'b1, $sformatf("R4 timeout code %0d", c));
    end

    // R5 repeated kicks hold off the request
    wr(8'h0A);
    kick_once();
    idle_w(8);
    p = npulse;
    for (int i = 0; i < 10; i++) begin
      kick_once();
      idle_w(16);
    end
    check(npulse == p, "R5 kicks prevent request", npulse - p, 0);
    measure(32, 1'b1, "R5 timeout after last kick");

    // R6 window length
    wr(8'h1A);
    check(rdata[4] == 1'b1, "R6 window open", int'(rdata[4]), 1);
    repeat (3) @(negedge clk);
    check(rdata[4] == 1'b1, "R6 window fourth cycle", int'(rdata[4]), 1);
    @(negedge clk);
    check(rdata[4] == 1'b0, "R6 window closed", int'(rdata[4]), 0);

    // R7 disable without window
    wr(8'h02);
    check(rdata == 8'h0A, "R7 disable without unlock", int'(rdata), 10);

    // R8 disable one cycle too late
    wr(8'h1A);
    repeat (4) @(negedge clk);
    wr(8'h02);
    check(rdata[3] == 1'b1, "R8 disable after window", int'(rdata[3]), 1);

    // R7 disable on last cycle of window
    wr(8'h1A);
    repeat (3) @(negedge clk);
    wr(8'h02);
    check(rdata[3] == 1'b0, "R7 disable on last window cycle", int'(rdata[3]), 0);

    // R10 disabled: quiet, then full period after re-enable
    p = npulse;
    idle_w(100);
    check(npulse == p, "R10 R3 quiet while disabled", npulse - p, 0);
    wr(8'h0A);
    measure(32, 1'b0, "R10 full period after enable");

    // R9 strict mode
    reset_dut(1'b1);
    wr(8'h0D);
    check(rdata == 8'h08, "R9 strict select locked", int'(rdata), 8);
    wr(8'h1D);
    check(rdata == 8'h18, "R9 strict select on unlock write", int'(rdata), 24);
    wr(8'h0D);
    check(rdata == 8'h1D, "R9 strict select in window", int'(rdata), 29);
    repeat (6) @(negedge clk);
    wr(8'h0B);
    check(rdata == 8'h0D, "R9 strict select after window", int'(rdata), 13);
    measure(256, 1'b1, "R9 R4 strict timeout code 5");

    finish_up();
  end
endmodule